// File: doc/BRIEF.md
# Register Rename Unit with Rename File

The block renames one decoded instruction per clock. Each instruction names one destination and two source architectural registers. The destination receives a newly allocated entry of a rename file. Both sources are translated through a mapping table into the rename identifiers that currently hold their youngest values. Every rename entry holds a data word, the architectural register it stands for, and a lifecycle state. That state is one of three: AVAIL (available), WAIT (allocated, value not yet produced) or READY (allocated, value present).

An execution unit returns results tagged with the renamed destination. Such a result fills the entry and moves it from WAIT to READY. Operand read ports take an architectural register number and return one of two things: the value of the mapped rename entry, together with a ready flag, or the architectural file's value when no mapping exists. A retire request names a rename entry. It copies a READY entry's value into the architectural file, frees the entry, and removes the mapping if that mapping still points at the entry.

Each entry is a small state machine. It has three states and four named transitions: ALLOCATE (AVAIL to WAIT, on issue), COMPLETE (WAIT to READY, on writeback), CANCEL (WAIT to AVAIL, on retire before the result arrives) and RETIRE (READY to AVAIL, on retire with copy to the architectural file). Any other input leaves the state unchanged.

Top module: `rename_unit`

## Requirements
- R1: After reset every entry is AVAIL, no architectural register is mapped, every architectural register reads 0 with hit low and ready high, and `iss_ready` is high.
- R2: An accepted issue (`iss_valid` and `iss_ready` both high) takes the lowest-numbered AVAIL entry and reports it on `iss_dst_tag` in that cycle. From the next cycle the destination register maps to that entry, which is in WAIT.
- R3: `iss_ready` is low exactly when no entry is AVAIL. An issue presented while `iss_ready` is low changes no entry and no mapping.
- R4: `iss_src1_hit`/`iss_src1_tag` and `iss_src2_hit`/`iss_src2_tag` give the source's mapping as it stood before the current instruction. This holds when a source equals the same instruction's destination.
- R5: A writeback to an entry in WAIT stores `wb_data` and moves the entry to READY. A writeback to an entry in AVAIL or READY is ignored.
- R6: A read of a mapped register gives `rd_hit`=1. It gives `rd_ready`=1 with the entry value when the entry is READY, and `rd_ready`=0 when the entry is WAIT. A read of an unmapped register gives `rd_hit`=0, `rd_ready`=1 and the architectural value.
- R7: Retiring a READY entry writes its value into the architectural register recorded at allocation, returns the entry to AVAIL, and unmaps that register if the mapping points at the entry.
- R8: A retire leaves the mapping unchanged when the register has since been mapped to a different entry.
- R9: Retiring a WAIT entry returns it to AVAIL without writing the architectural file, and a writeback in the same cycle to that entry is dropped. Retiring an AVAIL entry has no effect.
- R10: When an issue and a retire act on the same architectural register in one cycle, the new mapping wins. An entry freed by a retire can only be allocated from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Decoded instruction present |
| iss_dst | input | 3 | Destination architectural register |
| iss_src1 | input | 3 | First source architectural register |
| iss_src2 | input | 3 | Second source architectural register |
| iss_ready | output | 1 | A rename entry is available |
| iss_dst_tag | output | 3 | Entry allocated to the destination |
| iss_src1_hit | output | 1 | First source is mapped |
| iss_src1_tag | output | 3 | First source rename entry |
| iss_src2_hit | output | 1 | Second source is mapped |
| iss_src2_tag | output | 3 | Second source rename entry |
| wb_valid | input | 1 | Result from the execution unit |
| wb_tag | input | 3 | Rename entry of the result |
| wb_data | input | 32 | Result value |
| ret_valid | input | 1 | Retire request |
| ret_tag | input | 3 | Rename entry to retire |
| rd_addr | input | 2x3 | Architectural register per read port |
| rd_hit | output | 2 | Read register is mapped, per port |
| rd_ready | output | 2 | Read value is available, per port |
| rd_data | output | 2x32 | Read value, per port |

## Verification
A wrong entry state first appears on the ports through allocation. A leaked or doubly freed entry shifts `iss_dst_tag` or `iss_ready` on the next issue, and this can surface within one cycle. A stale or missing mapping shows up as a wrong hit flag or tag the next time the register is named as a source or read. A lost writeback or retire copy only becomes visible when the affected register is read. In that case `rd_ready` stays low, or the architectural value is wrong, so such faults can lie hidden for many cycles unless reads follow closely.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [1:0] {
        ENT_AVAIL = 2'd0,
        ENT_WAIT  = 2'd1,
        ENT_READY = 2'd2
    } ent_state_t;
endpackage

// File: rtl/rn_entry.sv
module rn_entry
    import rn_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int AW     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_i,
    input  logic [AW-1:0]     alloc_arch_i,
    input  logic              wb_i,
    input  logic [DATA_W-1:0] wb_data_i,
    input  logic              ret_i,
    output ent_state_t        state_o,
    output logic              is_free_o,
    output logic              has_value_o,
    output logic [DATA_W-1:0] data_o,
    output logic [AW-1:0]     arch_o
);
    ent_state_t        state_q, state_d;
    logic [DATA_W-1:0] data_q;
    logic [AW-1:0]     arch_q;

    // next-state: ALLOCATE, COMPLETE, CANCEL, RETIRE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ENT_AVAIL: if (alloc_i) state_d = ENT_WAIT;
            ENT_WAIT: begin
                if (ret_i)     state_d = ENT_AVAIL;
                else if (wb_i) state_d = ENT_READY;
            end
            ENT_READY: if (ret_i) state_d = ENT_AVAIL;
            default:   state_d = ENT_AVAIL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ENT_AVAIL;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            arch_q <= '0;
        end else begin
            if (state_q == ENT_WAIT && wb_i && !ret_i) data_q <= wb_data_i;
            if (state_q == ENT_AVAIL && alloc_i)       arch_q <= alloc_arch_i;
        end
    end

    always_comb begin
        is_free_o   = 1'b0;
        has_value_o = 1'b0;
        unique case (state_q)
            ENT_AVAIL: is_free_o   = 1'b1;
            ENT_WAIT:  has_value_o = 1'b0;
            ENT_READY: has_value_o = 1'b1;
            default:   is_free_o   = 1'b0;
        endcase
    end

    assign state_o = state_q;
    assign data_o  = data_q;
    assign arch_o  = arch_q;

    p_alloc_from_avail_r2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_i |-> state_q == ENT_AVAIL);
    p_ready_via_wb_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_READY && $past(state_q) != ENT_READY)
            |-> ($past(state_q) == ENT_WAIT && $past(wb_i)));
    p_retire_frees_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && state_q != ENT_AVAIL) |=> state_q == ENT_AVAIL);
    p_idle_avail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ENT_AVAIL && !alloc_i) |=> state_q == ENT_AVAIL);
endmodule

// File: rtl/rn_alloc.sv
module rn_alloc #(
    parameter int NUM_REN = 8,
    parameter int TW      = $clog2(NUM_REN)
) (
    input  logic [NUM_REN-1:0] free_i,
    output logic               found_o,
    output logic [TW-1:0]      idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_REN - 1; i >= 0; i--) begin
            if (free_i[i]) begin
                found_o = 1'b1;
                idx_o   = TW'(i);
            end
        end
    end

    always_comb begin
        if (found_o) p_pick_free_r2: assert (free_i[idx_o]);
    end
endmodule

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_REN  = 8,
    parameter int NUM_LK   = 4,
    parameter int AW       = $clog2(NUM_ARCH),
    parameter int TW       = $clog2(NUM_REN)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        iss_fire_i,
    input  logic [AW-1:0]               iss_dst_i,
    input  logic [TW-1:0]               iss_tag_i,
    input  logic                        clr_en_i,
    input  logic [AW-1:0]               clr_arch_i,
    input  logic [TW-1:0]               clr_tag_i,
    input  logic [NUM_LK-1:0][AW-1:0]   lk_addr_i,
    output logic [NUM_LK-1:0]           lk_hit_o,
    output logic [NUM_LK-1:0][TW-1:0]   lk_tag_o
);
    logic [NUM_ARCH-1:0]          map_v;
    logic [NUM_ARCH-1:0][TW-1:0]  map_t;
    logic                         clr_match;

    assign clr_match = clr_en_i && map_v[clr_arch_i] && (map_t[clr_arch_i] == clr_tag_i);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_v <= '0;
            map_t <= '0;
        end else begin
            if (clr_match) map_v[clr_arch_i] <= 1'b0;
            if (iss_fire_i) begin
                map_v[iss_dst_i] <= 1'b1;
                map_t[iss_dst_i] <= iss_tag_i;
            end
        end
    end

    for (genvar g = 0; g < NUM_LK; g++) begin : g_lk
        assign lk_hit_o[g] = map_v[lk_addr_i[g]];
        assign lk_tag_o[g] = map_t[lk_addr_i[g]];
    end

    p_issue_maps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        iss_fire_i |=> (map_v[$past(iss_dst_i)] && map_t[$past(iss_dst_i)] == $past(iss_tag_i)));
    p_keep_remapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en_i && !clr_match && !(iss_fire_i && iss_dst_i == clr_arch_i))
            |=> map_v[$past(clr_arch_i)] == $past(map_v[clr_arch_i]));
    p_issue_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_match && iss_fire_i && iss_dst_i == clr_arch_i) |=> map_v[$past(clr_arch_i)]);
endmodule

// File: rtl/rn_arch_file.sv
module rn_arch_file #(
    parameter int NUM_ARCH = 8,
    parameter int DATA_W   = 32,
    parameter int AW       = $clog2(NUM_ARCH)
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we_i,
    input  logic [AW-1:0]                    waddr_i,
    input  logic [DATA_W-1:0]                wdata_i,
    output logic [NUM_ARCH-1:0][DATA_W-1:0]  regs_o
);
    always_ff @(posedge clk) begin
        if (!rst_n)    regs_o <= '0;
        else if (we_i) regs_o[waddr_i] <= wdata_i;
    end
endmodule

// File: rtl/rename_unit.sv
module rename_unit
    import rn_pkg::*;
#(
    parameter int NUM_ARCH = 8,
    parameter int NUM_REN  = 8,
    parameter int DATA_W   = 32,
    parameter int NUM_RD   = 2,
    parameter int AW       = $clog2(NUM_ARCH),
    parameter int TW       = $clog2(NUM_REN)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            iss_valid,
    input  logic [AW-1:0]                   iss_dst,
    input  logic [AW-1:0]                   iss_src1,
    input  logic [AW-1:0]                   iss_src2,
    output logic                            iss_ready,
    output logic [TW-1:0]                   iss_dst_tag,
    output logic                            iss_src1_hit,
    output logic [TW-1:0]                   iss_src1_tag,
    output logic                            iss_src2_hit,
    output logic [TW-1:0]                   iss_src2_tag,
    input  logic                            wb_valid,
    input  logic [TW-1:0]                   wb_tag,
    input  logic [DATA_W-1:0]               wb_data,
    input  logic                            ret_valid,
    input  logic [TW-1:0]                   ret_tag,
    input  logic [NUM_RD-1:0][AW-1:0]       rd_addr,
    output logic [NUM_RD-1:0]               rd_hit,
    output logic [NUM_RD-1:0]               rd_ready,
    output logic [NUM_RD-1:0][DATA_W-1:0]   rd_data
);
    localparam int NUM_LK = 2 + NUM_RD;

    ent_state_t                      ent_state [NUM_REN];
    logic [NUM_REN-1:0]              ent_free;
    logic [NUM_REN-1:0]              ent_val;
    logic [DATA_W-1:0]               ent_data [NUM_REN];
    logic [AW-1:0]                   ent_arch [NUM_REN];
    logic                            iss_fire;
    logic [TW-1:0]                   alloc_idx;
    logic                            alloc_ok;
    ent_state_t                      ret_state;
    logic [AW-1:0]                   ret_arch;
    logic [DATA_W-1:0]               ret_data;
    logic                            arch_we;
    logic                            clr_en;
    logic [NUM_LK-1:0][AW-1:0]       lk_addr;
    logic [NUM_LK-1:0]               lk_hit;
    logic [NUM_LK-1:0][TW-1:0]       lk_tag;
    logic [NUM_ARCH-1:0][DATA_W-1:0] arch_regs;

    rn_alloc #(.NUM_REN(NUM_REN), .TW(TW)) u_alloc (
        .free_i (ent_free),
        .found_o(alloc_ok),
        .idx_o  (alloc_idx)
    );

    assign iss_ready   = alloc_ok;
    assign iss_dst_tag = alloc_idx;
    assign iss_fire    = iss_valid && alloc_ok;

    for (genvar i = 0; i < NUM_REN; i++) begin : g_ent
        rn_entry #(.DATA_W(DATA_W), .AW(AW)) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc_i     (iss_fire && alloc_idx == TW'(i)),
            .alloc_arch_i(iss_dst),
            .wb_i        (wb_valid && wb_tag == TW'(i)),
            .wb_data_i   (wb_data),
            .ret_i       (ret_valid && ret_tag == TW'(i)),
            .state_o     (ent_state[i]),
            .is_free_o   (ent_free[i]),
            .has_value_o (ent_val[i]),
            .data_o      (ent_data[i]),
            .arch_o      (ent_arch[i])
        );
    end

    assign ret_state = ent_state[ret_tag];
    assign ret_arch  = ent_arch[ret_tag];
    assign ret_data  = ent_data[ret_tag];
    assign arch_we   = ret_valid && ret_state == ENT_READY;
    assign clr_en    = ret_valid && ret_state != ENT_AVAIL;

    rn_arch_file #(.NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W), .AW(AW)) u_arch (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (arch_we),
        .waddr_i(ret_arch),
        .wdata_i(ret_data),
        .regs_o (arch_regs)
    );

    always_comb begin
        lk_addr[0] = iss_src1;
        lk_addr[1] = iss_src2;
        for (int p = 0; p < NUM_RD; p++) lk_addr[2 + p] = rd_addr[p];
    end

    rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_REN(NUM_REN), .NUM_LK(NUM_LK),
                   .AW(AW), .TW(TW)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_fire_i(iss_fire),
        .iss_dst_i (iss_dst),
        .iss_tag_i (alloc_idx),
        .clr_en_i  (clr_en),
        .clr_arch_i(ret_arch),
        .clr_tag_i (ret_tag),
        .lk_addr_i (lk_addr),
        .lk_hit_o  (lk_hit),
        .lk_tag_o  (lk_tag)
    );

    assign iss_src1_hit = lk_hit[0];
    assign iss_src1_tag = lk_tag[0];
    assign iss_src2_hit = lk_hit[1];
    assign iss_src2_tag = lk_tag[1];

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        assign rd_hit[p]   = lk_hit[2 + p];
        assign rd_ready[p] = !lk_hit[2 + p] || ent_val[lk_tag[2 + p]];
        assign rd_data[p]  = lk_hit[2 + p] ? ent_data[lk_tag[2 + p]] : arch_regs[rd_addr[p]];
    end

    p_arch_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arch_we |=> arch_regs[$past(ret_arch)] == $past(ret_data));
    p_stall_no_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_ready && !ret_valid) |=> !iss_ready);
    p_cancel_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && ret_state == ENT_WAIT) |=> $stable(arch_regs));
endmodule

// File: tb/rename_unit_tb.sv
module rename_unit_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              iss_valid = 1'b0;
    logic [2:0]        iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic              iss_ready;
    logic [2:0]        iss_dst_tag, iss_src1_tag, iss_src2_tag;
    logic              iss_src1_hit, iss_src2_hit;
    logic              wb_valid = 1'b0;
    logic [2:0]        wb_tag = '0;
    logic [31:0]       wb_data = '0;
    logic              ret_valid = 1'b0;
    logic [2:0]        ret_tag = '0;
    logic [1:0][2:0]   rd_addr = '0;
    logic [1:0]        rd_hit, rd_ready;
    logic [1:0][31:0]  rd_data;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // reference model: state 0 avail, 1 wait, 2 ready
    int          m_st [8];
    logic [31:0] m_ed [8];
    logic [2:0]  m_ea [8];
    bit          m_mv [8];
    logic [2:0]  m_mi [8];
    logic [31:0] m_arch [8];

    always #4 clk = ~clk;

    rename_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_ready(iss_ready), .iss_dst_tag(iss_dst_tag),
        .iss_src1_hit(iss_src1_hit), .iss_src1_tag(iss_src1_tag),
        .iss_src2_hit(iss_src2_hit), .iss_src2_tag(iss_src2_tag),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
        .ret_valid(ret_valid), .ret_tag(ret_tag),
        .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_ready(rd_ready), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int low_free();
        for (int i = 0; i < 8; i++) if (m_st[i] == 0) return i;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) begin
            m_st[i] = 0; m_ed[i] = '0; m_ea[i] = '0;
            m_mv[i] = 1'b0; m_mi[i] = '0; m_arch[i] = '0;
        end
    endtask

    task automatic check_outputs();
        int fi = low_free();
        chk(iss_ready == (fi >= 0), "R3", "iss_ready", iss_ready, fi >= 0);
        if (fi >= 0) chk(iss_dst_tag == fi[2:0], "R2", "iss_dst_tag", iss_dst_tag, fi);
        chk(iss_src1_hit == m_mv[iss_src1], "R4", "src1 hit", iss_src1_hit, m_mv[iss_src1]);
        if (m_mv[iss_src1]) chk(iss_src1_tag == m_mi[iss_src1], "R4", "src1 tag", iss_src1_tag, m_mi[iss_src1]);
        chk(iss_src2_hit == m_mv[iss_src2], "R4", "src2 hit", iss_src2_hit, m_mv[iss_src2]);
        if (m_mv[iss_src2]) chk(iss_src2_tag == m_mi[iss_src2], "R4", "src2 tag", iss_src2_tag, m_mi[iss_src2]);
        for (int p = 0; p < 2; p++) begin
            logic [2:0]  a = rd_addr[p];
            bit          eh = m_mv[a];
            bit          er = !eh || m_st[m_mi[a]] == 2;
            logic [31:0] ed = eh ? m_ed[m_mi[a]] : m_arch[a];
            chk(rd_hit[p] == eh, "R6", "rd_hit", rd_hit[p], eh);
            chk(rd_ready[p] == er, "R6", "rd_ready", rd_ready[p], er);
            if (er) chk(rd_data[p] == ed, "R6", "rd_data", rd_data[p], ed);
        end
    endtask

    task automatic model_step(input bit iv, input logic [2:0] d, input bit wv,
                              input logic [2:0] wt, input logic [31:0] wd,
                              input bit rv, input logic [2:0] rt);
        int st0 [8];
        int fi = low_free();
        for (int i = 0; i < 8; i++) st0[i] = m_st[i];
        if (rv && st0[rt] != 0) begin
            if (st0[rt] == 2) m_arch[m_ea[rt]] = m_ed[rt];
            m_st[rt] = 0;
            if (m_mv[m_ea[rt]] && m_mi[m_ea[rt]] == rt) m_mv[m_ea[rt]] = 1'b0;
        end
        if (wv && st0[wt] == 1 && !(rv && rt == wt)) begin
            m_ed[wt] = wd; m_st[wt] = 2;
        end
        if (iv && fi >= 0) begin
            m_st[fi] = 1; m_ea[fi] = d; m_mv[d] = 1'b1; m_mi[d] = fi[2:0];
        end
    endtask

    task automatic step(input bit iv, input logic [2:0] d, s1, s2,
                        input bit wv, input logic [2:0] wt, input logic [31:0] wd,
                        input bit rv, input logic [2:0] rt,
                        input logic [2:0] ra0, ra1);
        @(negedge clk);
        iss_valid = iv; iss_dst = d; iss_src1 = s1; iss_src2 = s2;
        wb_valid = wv; wb_tag = wt; wb_data = wd;
        ret_valid = rv; ret_tag = rt; rd_addr[0] = ra0; rd_addr[1] = ra1;
        #1;
        check_outputs();
        model_step(iv, d, wv, wt, wd, rv, rt);
    endtask

    task automatic probe(input logic [2:0] a0, a1);
        step(1'b0, 3'd0, a0, a1, 1'b0, 3'd0, 32'd0, 1'b0, 3'd0, a0, a1);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int r = 0; r < 8; r += 2) begin
            probe(r[2:0], r[2:0] + 3'd1);
            chk(rd_hit == 2'b00 && rd_ready == 2'b11, "R1", "reset hit/ready", {rd_hit, rd_ready}, 4'b0011);
            chk(rd_data == '0, "R1", "reset data", rd_data[0], 0);
            chk(iss_ready == 1'b1, "R1", "reset iss_ready", iss_ready, 1);
        end

        // R4/R2: source equal to own destination
        step(1, 3'd3, 3'd3, 3'd3, 0, 0, 0, 0, 0, 3'd3, 3'd3);
        chk(iss_src1_hit == 1'b0, "R4", "self src unmapped", iss_src1_hit, 0);
        chk(iss_dst_tag == 3'd0, "R2", "first tag", iss_dst_tag, 0);
        step(1, 3'd3, 3'd3, 3'd5, 0, 0, 0, 0, 0, 3'd3, 3'd5);
        chk(iss_src1_hit && iss_src1_tag == 3'd0, "R4", "self src old tag", iss_src1_tag, 0);
        chk(iss_dst_tag == 3'd1, "R2", "second tag", iss_dst_tag, 1);

        // R5/R6: writeback then read
        step(0, 0, 0, 0, 1, 3'd1, 32'hA5A5_0001, 0, 0, 3'd3, 3'd5);
        chk(rd_ready[0] == 1'b0, "R6", "pending not ready", rd_ready[0], 0);
        probe(3'd3, 3'd5);
        chk(rd_hit[0] && rd_ready[0] && rd_data[0] == 32'hA5A5_0001, "R5", "wb value", rd_data[0], 32'hA5A5_0001);
        step(0, 0, 0, 0, 1, 3'd1, 32'hDEAD_BEEF, 0, 0, 3'd3, 3'd5);
        probe(3'd3, 3'd5);
        chk(rd_data[0] == 32'hA5A5_0001, "R5", "wb to ready ignored", rd_data[0], 32'hA5A5_0001);

        // R9/R8: cancel the stale pending entry 0; reg3 stays on entry 1
        step(0, 0, 0, 0, 0, 0, 0, 1, 3'd0, 3'd3, 3'd5);
        probe(3'd3, 3'd3);
        chk(iss_src1_hit && iss_src1_tag == 3'd1, "R8", "mapping kept", iss_src1_tag, 1);

        // R7: retire entry 1
        step(0, 0, 0, 0, 0, 0, 0, 1, 3'd1, 3'd3, 3'd5);
        probe(3'd3, 3'd5);
        chk(!rd_hit[0] && rd_data[0] == 32'hA5A5_0001, "R7", "arch copy", rd_data[0], 32'hA5A5_0001);

        // R3: fill all entries, then stall
        for (int i = 0; i < 8; i++) step(1, i[2:0], 0, 0, 0, 0, 0, 0, 0, 3'd0, 3'd1);
        probe(3'd0, 3'd1);
        chk(iss_ready == 1'b0, "R3", "full stall", iss_ready, 0);
        step(1, 3'd6, 0, 0, 0, 0, 0, 0, 0, 3'd6, 3'd6);
        step(0, 0, 0, 0, 0, 0, 0, 1, 3'd5, 3'd0, 3'd1);
        probe(3'd5, 3'd6);
        chk(iss_ready && iss_dst_tag == 3'd5, "R3", "stalled issue took nothing", iss_dst_tag, 5);
        chk(iss_src2_hit && iss_src2_tag == 3'd6, "R3", "stalled map kept", iss_src2_tag, 6);

        // R10: issue dst4 and retire entry 4 (mapped by reg4) together
        step(1, 3'd4, 0, 0, 0, 0, 0, 1, 3'd4, 3'd4, 3'd4);
        chk(iss_dst_tag == 3'd5, "R10", "freed entry not reused same cycle", iss_dst_tag, 5);
        probe(3'd4, 3'd4);
        chk(iss_src1_hit && iss_src1_tag == 3'd5, "R10", "new mapping wins", iss_src1_tag, 5);
        chk(iss_ready && iss_dst_tag == 3'd4, "R10", "freed entry next cycle", iss_dst_tag, 4);

        // random traffic, covers R1..R10 via the model
        for (int c = 0; c < 4000; c++) begin
            bit iv = ($urandom % 10) < 6;
            bit wv = ($urandom % 10) < 5;
            bit rv = ($urandom % 10) < 4;
            step(iv, 3'($urandom), 3'($urandom), 3'($urandom),
                 wv, 3'($urandom), $urandom, rv, 3'($urandom),
                 3'($urandom), 3'($urandom));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule